// File: doc/BRIEF.md
# Video output source multiplexer with level insertion

This block sits in front of three 11-bit DAC codes in a video output path. Each pixel clock it picks the value for each of the three output channels. The value is either the incoming video sample or a generated timing level: blank, sync-low or sync-high. The choice depends on three things: the timing mode, the kind of the current line, and an option that lets video through on lines that are only partly active. Channel 0 carries luma (or green) and takes its generated levels from the luma set. Channels 1 and 2 carry the colour-difference components and take theirs from the chroma set.

A headroom offset leaves room for a negative-going sync below the blanking level. In RGB mode the offset is added to all three channels. In YPbPr mode it is added to channel 0 only, and the two chroma channels keep their plain offset-binary codes. The addition saturates at the top code. Every path passes through exactly one output register, so all channels change on the same clock edge.

Top module: `avmux_top`

## Requirements
- R1: While `rst` is high at a clock edge, all three DAC outputs become 0 at that edge.
- R2: Every path has exactly one clock of latency, and all three channels update on the same edge.
- R3: With `timing_mode` = 00 (PC graphics), the outputs always carry input video. `line_kind`, `in_active`, `pass_en` and `sync_state` have no effect.
- R4: With `timing_mode` 01, 10 or 11 and `line_kind` = 00 (full video line), the output is input video when `in_active` = 1 and a generated level when `in_active` = 0.
- R5: With `timing_mode` non-zero and `line_kind` = 10 or 11 (line with no active part), the output is a generated level regardless of `in_active` and `pass_en`.
- R6: With `timing_mode` non-zero and `line_kind` = 01 (line with a partial active part), the output is input video only when `pass_en` = 1 and `in_active` = 1. Otherwise it is a generated level.
- R7: The generated level follows `sync_state`: 00 gives blank, 01 gives sync-low, 10 gives sync-high and 11 gives blank. Channel 0 uses the luma set and channels 1 and 2 use the chroma set.
- R8: With `rgb_mode` = 1, the offset HEADROOM (default 400) is added to all three channels.
- R9: With `rgb_mode` = 0, HEADROOM is added to channel 0 only. Channels 1 and 2 are output unchanged.
- R10: An offset sum above 2047 gives 2047. It never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| timing_mode | input | 2 | 00 PC graphics, 01 standard definition, 10/11 high definition |
| line_kind | input | 2 | 00 full video, 01 partial active, 10/11 no active part |
| in_active | input | 1 | Current pixel lies in the active region |
| pass_en | input | 1 | Lets video through on partial lines |
| rgb_mode | input | 1 | 1 RGB, 0 YPbPr |
| sync_state | input | 2 | 00 blank, 01 sync-low, 10 sync-high, 11 blank |
| vid_ch0 | input | 11 | Video input, luma/green |
| vid_ch1 | input | 11 | Video input, chroma 1 |
| vid_ch2 | input | 11 | Video input, chroma 2 |
| luma_blank | input | 11 | Luma blank level |
| luma_sync_lo | input | 11 | Luma sync-low level |
| luma_sync_hi | input | 11 | Luma sync-high level |
| chroma_blank | input | 11 | Chroma blank level |
| chroma_sync_lo | input | 11 | Chroma sync-low level |
| chroma_sync_hi | input | 11 | Chroma sync-high level |
| dac_ch0 | output | 11 | Registered DAC code, channel 0 |
| dac_ch1 | output | 11 | Registered DAC code, channel 1 |
| dac_ch2 | output | 11 | Registered DAC code, channel 2 |

## Verification
The assertions are checked on every cycle. They cover the one-cycle relations for the plain cases. Chroma passes unchanged in PC mode and on active parts of full lines. Chroma blank is inserted on lines with no active part. Video passes on partial lines when the pass-through option is set. Channel 0 saturates near the top code in RGB mode.

Some behaviours are shown only by the bench scenarios:
- the full `sync_state` level table on each channel;
- offset behaviour at the exact saturation boundary;
- reset values;
- the outputs holding their old values until the next edge.

// File: rtl/avmux_pkg.sv
package avmux_pkg;
  typedef enum logic [1:0] {
    MODE_PC  = 2'b00,
    MODE_SD  = 2'b01,
    MODE_HD  = 2'b10,
    MODE_HDX = 2'b11
  } tmode_e;

  typedef enum logic [1:0] {
    LK_FULL  = 2'b00,
    LK_PART  = 2'b01,
    LK_NONE  = 2'b10,
    LK_NONEX = 2'b11
  } lkind_e;

  typedef enum logic [1:0] {
    SS_BLANK = 2'b00,
    SS_LOW   = 2'b01,
    SS_HIGH  = 2'b10,
    SS_RSV   = 2'b11
  } sstate_e;

  localparam int NUM_CH = 3;
endpackage

// File: rtl/avmux_route.sv
module avmux_route
  import avmux_pkg::*;
(
  input  logic [1:0] timing_mode,
  input  logic [1:0] line_kind,
  input  logic       in_active,
  input  logic       pass_en,
  output logic       use_video
);
  always_comb begin
    if (timing_mode == MODE_PC) begin
      use_video = 1'b1;
    end else begin
      case (line_kind)
        LK_FULL: use_video = in_active;
        LK_PART: use_video = in_active & pass_en;
        default: use_video = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/avmux_level.sv
module avmux_level
  import avmux_pkg::*;
#(
  parameter int W = 11
) (
  input  logic [1:0]   sync_state,
  input  logic [W-1:0] lvl_blank,
  input  logic [W-1:0] lvl_low,
  input  logic [W-1:0] lvl_high,
  output logic [W-1:0] level
);
  always_comb begin
    case (sync_state)
      SS_LOW:  level = lvl_low;
      SS_HIGH: level = lvl_high;
      default: level = lvl_blank;
    endcase
  end
endmodule

// File: rtl/avmux_satadd.sv
module avmux_satadd #(
  parameter int W = 11
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] off,
  input  logic         en,
  output logic [W-1:0] y
);
  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, a} + (en ? {1'b0, off} : '0);
    y   = sum[W] ? {W{1'b1}} : sum[W-1:0];
  end
endmodule

// File: rtl/avmux_top.sv
module avmux_top
  import avmux_pkg::*;
#(
  parameter int          W        = 11,
  parameter logic [10:0] HEADROOM = 11'd400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   timing_mode,
  input  logic [1:0]   line_kind,
  input  logic         in_active,
  input  logic         pass_en,
  input  logic         rgb_mode,
  input  logic [1:0]   sync_state,
  input  logic [W-1:0] vid_ch0,
  input  logic [W-1:0] vid_ch1,
  input  logic [W-1:0] vid_ch2,
  input  logic [W-1:0] luma_blank,
  input  logic [W-1:0] luma_sync_lo,
  input  logic [W-1:0] luma_sync_hi,
  input  logic [W-1:0] chroma_blank,
  input  logic [W-1:0] chroma_sync_lo,
  input  logic [W-1:0] chroma_sync_hi,
  output logic [W-1:0] dac_ch0,
  output logic [W-1:0] dac_ch1,
  output logic [W-1:0] dac_ch2
);
  localparam logic [W-1:0] OFF_CODE = W'(HEADROOM);

  logic           use_video;
  logic [W-1:0]   vid   [NUM_CH];
  logic [W-1:0]   lvl   [NUM_CH];
  logic [W-1:0]   pick  [NUM_CH];
  logic [W-1:0]   shift [NUM_CH];
  logic [W-1:0]   dac_q [NUM_CH];

  assign vid[0] = vid_ch0;
  assign vid[1] = vid_ch1;
  assign vid[2] = vid_ch2;

  avmux_route u_route (
    .timing_mode (timing_mode),
    .line_kind   (line_kind),
    .in_active   (in_active),
    .pass_en     (pass_en),
    .use_video   (use_video)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (c == 0) begin : g_luma
      avmux_level #(.W(W)) u_level (
        .sync_state (sync_state),
        .lvl_blank  (luma_blank),
        .lvl_low    (luma_sync_lo),
        .lvl_high   (luma_sync_hi),
        .level      (lvl[c])
      );
    end else begin : g_chroma
      avmux_level #(.W(W)) u_level (
        .sync_state (sync_state),
        .lvl_blank  (chroma_blank),
        .lvl_low    (chroma_sync_lo),
        .lvl_high   (chroma_sync_hi),
        .level      (lvl[c])
      );
    end

    assign pick[c] = use_video ? vid[c] : lvl[c];

    avmux_satadd #(.W(W)) u_add (
      .a   (pick[c]),
      .off (OFF_CODE),
      .en  ((c == 0) ? 1'b1 : rgb_mode),
      .y   (shift[c])
    );

    always_ff @(posedge clk) begin
      if (rst) dac_q[c] <= '0;
      else     dac_q[c] <= shift[c];
    end
  end

  assign dac_ch0 = dac_q[0];
  assign dac_ch1 = dac_q[1];
  assign dac_ch2 = dac_q[2];
endmodule

// File: rtl/avmux_checker.sv
module avmux_checker #(
  parameter int          W        = 11,
  parameter logic [10:0] HEADROOM = 11'd400
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   timing_mode,
  input logic [1:0]   line_kind,
  input logic         in_active,
  input logic         pass_en,
  input logic         rgb_mode,
  input logic [1:0]   sync_state,
  input logic [W-1:0] vid_ch0,
  input logic [W-1:0] vid_ch1,
  input logic [W-1:0] vid_ch2,
  input logic [W-1:0] chroma_blank,
  input logic [W-1:0] dac_ch0,
  input logic [W-1:0] dac_ch1,
  input logic [W-1:0] dac_ch2
);
  localparam logic [W:0] SAT_FROM = (W+1)'((1 << W) - int'(HEADROOM));

  // R3, R9: PC mode in YPbPr passes chroma untouched
  p_pc_chroma_r3: assert property (@(posedge clk) disable iff (rst)
    (timing_mode == 2'b00 && !rgb_mode)
    |=> (dac_ch1 == $past(vid_ch1) && dac_ch2 == $past(vid_ch2)));

  // R4: active part of a full line carries video
  p_full_active_r4: assert property (@(posedge clk) disable iff (rst)
    (timing_mode != 2'b00 && line_kind == 2'b00 && in_active && !rgb_mode)
    |=> (dac_ch1 == $past(vid_ch1)));

  // R5, R7: no-active line with blank state drives chroma blank
  p_none_blank_r5: assert property (@(posedge clk) disable iff (rst)
    (timing_mode != 2'b00 && line_kind[1] && sync_state == 2'b00 && !rgb_mode)
    |=> (dac_ch1 == $past(chroma_blank) && dac_ch2 == $past(chroma_blank)));

  // R6: pass-through lets video through on partial lines
  p_partial_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (timing_mode != 2'b00 && line_kind == 2'b01 && pass_en && in_active && !rgb_mode)
    |=> (dac_ch2 == $past(vid_ch2)));

  // R10: offset never wraps past the top code
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (timing_mode == 2'b00 && {1'b0, vid_ch0} >= SAT_FROM)
    |=> (dac_ch0 == {W{1'b1}}));
endmodule

bind avmux_top avmux_checker #(.W(W), .HEADROOM(HEADROOM)) u_avmux_chk (
  .clk          (clk),
  .rst          (rst),
  .timing_mode  (timing_mode),
  .line_kind    (line_kind),
  .in_active    (in_active),
  .pass_en      (pass_en),
  .rgb_mode     (rgb_mode),
  .sync_state   (sync_state),
  .vid_ch0      (vid_ch0),
  .vid_ch1      (vid_ch1),
  .vid_ch2      (vid_ch2),
  .chroma_blank (chroma_blank),
  .dac_ch0      (dac_ch0),
  .dac_ch1      (dac_ch1),
  .dac_ch2      (dac_ch2)
);

// File: tb/test_avmux_top.sv
`timescale 1ns/1ps
module test_avmux_top;
  localparam int W   = 11;
  localparam int OFF = 400;
  localparam int LB = 300, LL = 40, LH = 700;
  localparam int CB = 1024, CL = 100, CH = 1900;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] timing_mode = 2'b00, line_kind = 2'b00, sync_state = 2'b00;
  logic in_active = 1'b0, pass_en = 1'b0, rgb_mode = 1'b0;
  logic [W-1:0] vid_ch0 = '0, vid_ch1 = '0, vid_ch2 = '0;
  logic [W-1:0] luma_blank = W'(LB), luma_sync_lo = W'(LL), luma_sync_hi = W'(LH);
  logic [W-1:0] chroma_blank = W'(CB), chroma_sync_lo = W'(CL), chroma_sync_hi = W'(CH);
  logic [W-1:0] dac_ch0, dac_ch1, dac_ch2;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  avmux_top #(.W(W), .HEADROOM(11'd400)) i_avmux_top (.*);

  function automatic int sat(input int v);
    return (v > 2047) ? 2047 : v;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_vid(input int a, input int b, input int c);
    vid_ch0 = W'(a); vid_ch1 = W'(b); vid_ch2 = W'(c);
  endtask

  task automatic chk3(input string req, input int e0, input int e1, input int e2);
    chk(req, "ch0", int'(dac_ch0), e0);
    chk(req, "ch1", int'(dac_ch1), e1);
    chk(req, "ch2", int'(dac_ch2), e2);
  endtask

  task automatic t_reset();
    rst = 1'b1; put_vid(500, 600, 700);
    step();
    chk3("R1", 0, 0, 0);
    rst = 1'b0;
  endtask

  task automatic t_pc_mode();
    timing_mode = 2'b00; rgb_mode = 1'b0;
    line_kind = 2'b10; in_active = 1'b0; pass_en = 1'b0; sync_state = 2'b01;
    put_vid(100, 200, 300);
    step();
    chk3("R3", 100 + OFF, 200, 300);
    line_kind = 2'b01; sync_state = 2'b10; put_vid(5, 6, 7);
    step();
    chk3("R9", 5 + OFF, 6, 7);
  endtask

  task automatic t_full_line();
    timing_mode = 2'b01; rgb_mode = 1'b0; line_kind = 2'b00; pass_en = 1'b0;
    in_active = 1'b1; sync_state = 2'b01; put_vid(111, 222, 333);
    step();
    chk3("R4", 111 + OFF, 222, 333);
    in_active = 1'b0;
    step();
    chk3("R4", LL + OFF, CL, CL);
  endtask

  task automatic t_no_active();
    timing_mode = 2'b10; rgb_mode = 1'b0; line_kind = 2'b10;
    in_active = 1'b1; pass_en = 1'b1; put_vid(900, 901, 902);
    sync_state = 2'b00; step(); chk3("R5", LB + OFF, CB, CB);
    sync_state = 2'b01; step(); chk3("R7", LL + OFF, CL, CL);
    sync_state = 2'b10; step(); chk3("R7", LH + OFF, CH, CH);
    line_kind = 2'b11; timing_mode = 2'b11;
    sync_state = 2'b11; step(); chk3("R7", LB + OFF, CB, CB);
  endtask

  task automatic t_partial();
    timing_mode = 2'b01; rgb_mode = 1'b0; line_kind = 2'b01; sync_state = 2'b00;
    put_vid(50, 60, 70);
    pass_en = 1'b0; in_active = 1'b1; step(); chk3("R6", LB + OFF, CB, CB);
    pass_en = 1'b1; in_active = 1'b1; step(); chk3("R6", 50 + OFF, 60, 70);
    pass_en = 1'b1; in_active = 1'b0; step(); chk3("R6", LB + OFF, CB, CB);
  endtask

  task automatic t_rgb();
    timing_mode = 2'b00; rgb_mode = 1'b1; put_vid(10, 20, 30);
    step(); chk3("R8", 10 + OFF, 20 + OFF, 30 + OFF);
    timing_mode = 2'b10; line_kind = 2'b10; sync_state = 2'b10;
    step(); chk3("R8", LH + OFF, sat(CH + OFF), sat(CH + OFF));
  endtask

  task automatic t_sat();
    timing_mode = 2'b00; rgb_mode = 1'b1;
    put_vid(1646, 1647, 2000);
    step(); chk3("R10", 2046, 2047, 2047);
    put_vid(2047, 1648, 0);
    step(); chk3("R10", 2047, 2047, OFF);
  endtask

  task automatic t_latency();
    timing_mode = 2'b00; rgb_mode = 1'b0; put_vid(1, 2, 3);
    step();
    put_vid(400, 500, 600);
    #0.5;
    chk3("R2", 1 + OFF, 2, 3);
    step();
    chk3("R2", 400 + OFF, 500, 600);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_pc_mode();
    t_full_line();
    t_no_active();
    t_partial();
    t_rgb();
    t_sat();
    t_latency();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule